// File: doc/BRIEF.md
# Repeated String Operation Engine

This block performs one string operation element after another under a repeat count. The operation is a move, a compare or a scan, and the block repeats it until the count runs out or a zero-flag condition ends the loop. One start pulse loads every control field and the initial register values. The block then walks the source and destination offsets through a byte-wide memory port that uses a request/acknowledge handshake.

Each element is a byte or a 16-bit word. A word takes two byte accesses, and the low byte sits at the lower address. The offsets move up or down by the element size after each element, depending on the direction input. A single-cycle done pulse ends the run. The final offsets, the remaining count and the zero flag then stay on the outputs until the next start.

Addresses are flat offsets. Segment arithmetic and instruction decoding are left to the surrounding logic.

Top module: `rep_string_engine`

## Requirements
- R1: The operation code `op` is encoded as 00 for move, 01 for compare and 10 for scan. The repeat mode `mode` is encoded as 00 for unconditional (11 behaves the same), 01 for repeat-while-equal and 10 for repeat-while-not-equal. When a run starts with a nonzero count in unconditional mode, exactly that many elements are processed and the count output ends at 0.
- R2: After each element, every offset that the operation uses advances by the element size when `dir` is 0 and retreats by it when `dir` is 1. Move and compare use both offsets. Scan uses only the destination offset and leaves the source offset unchanged.
- R3: With `wide`=0 an element is one byte and the step is 1. With `wide`=1 an element is a word and the step is 2. A word occupies two bytes, low byte at offset+0 and high byte at offset+1, and this holds in both directions.
- R4: A move writes the element read at the source offset to the destination offset. A move never alters the zero flag.
- R5: A compare reads the source element and the destination element. It sets the zero flag when the two are equal and clears it otherwise.
- R6: A scan compares the accumulator value with the destination element (low 8 bits for bytes, all 16 bits for words) and sets or clears the zero flag the same way as a compare.
- R7: In repeat-while-equal mode, a compare or scan run stops after the first element that leaves the zero flag at 0.
- R8: In repeat-while-not-equal mode, a compare or scan run stops after the first element that leaves the zero flag at 1.
- R9: A start with count 0 makes no memory request. Done is high in the cycle after start is sampled, and the offsets and count equal their initial values.
- R10: Done is high for exactly one cycle. After it, the offsets, count and zero flag hold their values until the next start.
- R11: The count drops by exactly one after each element.
- R12: Once the block raises `mem_req`, it holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads the fields below and begins a run (ignored while busy) |
| op | input | 2 | Operation: 00 move, 01 compare, 10 scan |
| mode | input | 2 | Repeat mode: 00 unconditional, 01 while equal, 10 while not equal |
| wide | input | 1 | 0 byte elements, 1 word elements |
| dir | input | 1 | 0 increments the offsets, 1 decrements them |
| src_init | input | AW | Initial source offset |
| dst_init | input | AW | Initial destination offset |
| cnt_init | input | CW | Initial repeat count |
| acc_init | input | 16 | Accumulator value that a scan compares against |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while mem_ack is high |
| mem_ack | input | 1 | Completes the pending access |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Single-cycle end-of-run pulse |
| src_idx | output | AW | Current source offset |
| dst_idx | output | AW | Current destination offset |
| count | output | CW | Current repeat count |
| zf | output | 1 | Zero flag |

## Verification
The bench aims at the early-exit paths. A match found partway through a while-not-equal scan and a mismatch partway through a while-equal compare must both stop the run with the count and offsets at exactly that element. A design that tests the flag before the element, or keeps going one element too far, leaves the count off by one.

A zero count must finish without touching memory. A design that tests the count only after the first element would make an access and wrap the count.

Word runs going backwards check that the low byte still lands at the lower address and that the offsets step by two. Swapped byte lanes or a step of one corrupt the copied data.

A move that follows a compare must leave the zero flag alone. A scan must leave the source offset where it was.

// File: rtl/rep_string_engine.sv
module rep_string_engine #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [1:0]    mode,
  input  logic          wide,
  input  logic          dir,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [15:0]   acc_init,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_idx,
  output logic [AW-1:0] dst_idx,
  output logic [CW-1:0] count,
  output logic          zf
);

  localparam logic [1:0] OP_MOVE = 2'd0;
  localparam logic [1:0] OP_SCAN = 2'd2;
  localparam logic [1:0] RM_EQ   = 2'd1;
  localparam logic [1:0] RM_NE   = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RDA, S_RDB, S_WR, S_STEP} state_t;

  state_t        state;
  logic [1:0]    op_q, mode_q;
  logic          wide_q, dir_q, hi;
  logic [15:0]   a_q, b_q, acc_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          zf_q, done_q;

  wire [AW-1:0] stride   = wide_q ? AW'(2) : AW'(1);
  wire [15:0]   opa      = (op_q == OP_SCAN) ? acc_q : a_q;
  wire          eq       = wide_q ? (opa == b_q) : (opa[7:0] == b_q[7:0]);
  wire          last_cnt = (cnt_q == CW'(1));
  wire          flag_op  = (op_q != OP_MOVE);
  wire          stop_flg = flag_op && ((mode_q == RM_EQ && !eq) || (mode_q == RM_NE && eq));
  wire          last_byte = !wide_q || hi;
  wire          first_rb = (op == OP_SCAN);

  assign mem_req   = (state == S_RDA) || (state == S_RDB) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = ((state == S_RDA) ? src_q : dst_q) + AW'(hi);
  assign mem_wdata = hi ? a_q[15:8] : a_q[7:0];
  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign src_idx   = src_q;
  assign dst_idx   = dst_q;
  assign count     = cnt_q;
  assign zf        = zf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_MOVE;
      mode_q <= 2'd0;
      wide_q <= 1'b0;
      dir_q  <= 1'b0;
      hi     <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      zf_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q   <= op;
          mode_q <= mode;
          wide_q <= wide;
          dir_q  <= dir;
          acc_q  <= acc_init;
          src_q  <= src_init;
          dst_q  <= dst_init;
          cnt_q  <= cnt_init;
          hi     <= 1'b0;
          if (cnt_init == '0) done_q <= 1'b1;
          else state <= first_rb ? S_RDB : S_RDA;
        end
        S_RDA: if (mem_ack) begin
          if (hi) a_q[15:8] <= mem_rdata;
          else    a_q[7:0]  <= mem_rdata;
          hi <= !last_byte;
          if (last_byte) state <= (op_q == OP_MOVE) ? S_WR : S_RDB;
        end
        S_RDB: if (mem_ack) begin
          if (hi) b_q[15:8] <= mem_rdata;
          else    b_q[7:0]  <= mem_rdata;
          hi <= !last_byte;
          if (last_byte) state <= S_STEP;
        end
        S_WR: if (mem_ack) begin
          hi <= !last_byte;
          if (last_byte) state <= S_STEP;
        end
        S_STEP: begin
          if (op_q != OP_SCAN) src_q <= dir_q ? src_q - stride : src_q + stride;
          dst_q <= dir_q ? dst_q - stride : dst_q + stride;
          cnt_q <= cnt_q - CW'(1);
          if (flag_op) zf_q <= eq;
          if (last_cnt || stop_flg) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= (op_q == OP_SCAN) ? S_RDB : S_RDA;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(src_idx) && $stable(dst_idx) && $stable(count) && $stable(zf));

  // R11
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_STEP |=> count == CW'($past(count) - CW'(1)));

  // R2
  src_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_STEP && !dir_q && op_q != OP_SCAN |=> src_idx == AW'($past(src_idx) + $past(stride)));

  // R2
  dst_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_STEP && dir_q |=> dst_idx == AW'($past(dst_idx) - $past(stride)));

  // R4
  move_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_q == OP_MOVE |=> $stable(zf));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

endmodule

// File: tb/rep_string_engine_tb.sv
module rep_string_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0, mode = 2'd0;
  logic        wide = 1'b0, dir = 1'b0;
  logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0, acc_init = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic        busy, done, zf;
  logic [15:0] src_idx, dst_idx, count;

  logic [7:0] mem [0:255];
  int n_vec = 0, n_bad = 0, n_acc = 0, lat = 0;

  always #5 clk = ~clk;

  rep_string_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode), .wide(wide),
    .dir(dir), .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
    .acc_init(acc_init), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy),
    .done(done), .src_idx(src_idx), .dst_idx(dst_idx), .count(count), .zf(zf));

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      n_acc++;
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      else mem_rdata = mem[mem_addr[7:0]];
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [1:0] m, input logic w,
                     input logic d, input int s, input int t, input int c, input int a);
    @(negedge clk);
    op = o; mode = m; wide = w; dir = d;
    src_init = 16'(s); dst_init = 16'(t); cnt_init = 16'(c); acc_init = 16'(a);
    start = 1'b1;
    n_acc = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset done", int'(done), 0);
    chk("R11 reset count", int'(count), 0);
    chk("R5 reset zf", int'(zf), 0);
  endtask

  task automatic t_cmp_uncond();
    for (int i = 0; i < 3; i++) begin
      mem[8'h80 + i] = 8'(8'h10 + i);
      mem[8'h90 + i] = (i == 0) ? 8'hEE : 8'(8'h10 + i);
    end
    run(2'd1, 2'd0, 1'b0, 1'b0, 'h80, 'h90, 3, 0);
    chk("R1 cmp uncond count", int'(count), 0);
    chk("R1 cmp uncond src", int'(src_idx), 'h83);
    chk("R5 cmp last equal zf", int'(zf), 1);
    chk("R1 cmp accesses", n_acc, 6);
  endtask

  task automatic t_move_fwd();
    for (int i = 0; i < 5; i++) begin
      mem[8'h10 + i] = 8'(8'hA0 + i);
      mem[8'h40 + i] = 8'h00;
    end
    run(2'd0, 2'd1, 1'b0, 1'b0, 'h10, 'h40, 5, 0);
    for (int i = 0; i < 5; i++) chk("R4 move byte data", int'(mem[8'h40 + i]), 'hA0 + i);
    chk("R2 move fwd src", int'(src_idx), 'h15);
    chk("R2 move fwd dst", int'(dst_idx), 'h45);
    chk("R1 move count", int'(count), 0);
    chk("R4 move keeps zf", int'(zf), 1);
  endtask

  task automatic t_move_back_word();
    for (int i = 0; i < 6; i++) begin
      mem[8'h2A + i] = 8'(8'h50 + i);
      mem[8'h6A + i] = 8'h00;
    end
    run(2'd0, 2'd0, 1'b1, 1'b1, 'h2E, 'h6E, 3, 0);
    for (int i = 0; i < 6; i++) chk("R3 word move bytes", int'(mem[8'h6A + i]), 'h50 + i);
    chk("R3 word back src", int'(src_idx), 'h28);
    chk("R2 word back dst", int'(dst_idx), 'h68);
    chk("R11 word count", int'(count), 0);
    chk("R3 word accesses", n_acc, 12);
  endtask

  task automatic t_cmp_while_eq();
    for (int i = 0; i < 8; i++) begin
      mem[8'hB0 + i] = 8'(i);
      mem[8'hC0 + i] = (i == 3) ? 8'h77 : 8'(i);
    end
    run(2'd1, 2'd1, 1'b0, 1'b0, 'hB0, 'hC0, 8, 0);
    chk("R7 eq stop count", int'(count), 4);
    chk("R7 eq stop src", int'(src_idx), 'hB4);
    chk("R7 eq stop dst", int'(dst_idx), 'hC4);
    chk("R5 mismatch zf", int'(zf), 0);
  endtask

  task automatic t_scan_while_ne();
    for (int i = 0; i < 10; i++) mem[8'hD0 + i] = (i == 3) ? 8'h5A : 8'(8'h30 + i);
    run(2'd2, 2'd2, 1'b0, 1'b0, 'h11, 'hD0, 10, 'h995A);
    chk("R8 ne stop count", int'(count), 6);
    chk("R8 ne stop dst", int'(dst_idx), 'hD4);
    chk("R6 scan found zf", int'(zf), 1);
    chk("R2 scan src untouched", int'(src_idx), 'h11);
    chk("R6 scan reads only dst", n_acc, 4);
  endtask

  task automatic t_scan_word_eq();
    mem[8'hE0] = 8'h34; mem[8'hE1] = 8'h12;
    mem[8'hE2] = 8'h34; mem[8'hE3] = 8'h12;
    mem[8'hE4] = 8'h34; mem[8'hE5] = 8'h13;
    run(2'd2, 2'd1, 1'b1, 1'b0, 0, 'hE0, 5, 'h1234);
    chk("R6 word scan count", int'(count), 2);
    chk("R3 word scan dst", int'(dst_idx), 'hE6);
    chk("R7 word scan zf", int'(zf), 0);
  endtask

  task automatic t_zero_count();
    run(2'd0, 2'd0, 1'b0, 1'b0, 'h20, 'h30, 0, 0);
    chk("R9 zero latency", lat, 1);
    chk("R9 zero no access", n_acc, 0);
    chk("R9 zero src", int'(src_idx), 'h20);
    chk("R9 zero dst", int'(dst_idx), 'h30);
    chk("R9 zero count", int'(count), 0);
  endtask

  task automatic t_done_pulse();
    run(2'd1, 2'd0, 1'b0, 1'b0, 'h80, 'h90, 2, 0);
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
    chk("R10 count held", int'(count), 0);
    chk("R10 src held", int'(src_idx), 'h82);
    repeat (3) @(negedge clk);
    chk("R10 dst held", int'(dst_idx), 'h92);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmp_uncond();
    t_move_fwd();
    t_move_back_word();
    t_cmp_while_eq();
    t_scan_while_ne();
    t_scan_word_eq();
    t_zero_count();
    t_done_pulse();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule